// File: doc/BRIEF.md
# AC Power Loss Recovery Controller

This block decides, each time standby power returns, whether the system should be switched back on. It holds one 8-bit control and status register. Some of its fields live in the battery-backed domain and survive loss of standby power. Others are restored by the standby power-on reset, and a lock field is also cleared by a main-power or bus reset. Software writes the register through a plain write strobe, and the register is always visible on a read bus.

While history sampling is enabled, a slow external strobe shifts the state of the active-low supply-on input into a history register. The strobe nominally arrives every half second, so eight entries span about four seconds. While the power-loss indication is high, the block copies the most recent known supply state into a read-only battery-backed bit.

On the first clock after the standby reset is released, the block applies the selected restore policy. When that policy resolves to "on" and recovery is enabled, it drives a fixed-length low pulse on an active-low power-button output. The block never drives the supply-on pin itself.

Top module: `pwr_restore_ctrl`

## Requirements
- R1: After battery and standby power-on resets together, the register reads 0x03. Bit 0 is button enable, bit 1 is keyboard-button enable, bit 2 is recovery enable, bit 3 is sampling enable, bit 4 is previous state, bits 6:5 are the policy and bit 7 is the lock.
- R2: While bit 7 reads 0, a write strobe loads bits 0-3 and 5-7 from the write data. The new value is visible on the next cycle.
- R3: While bit 3 is 1, each cycle with the sample strobe high shifts a new entry into an 8-deep history, with 1 meaning the supply-on input is low. While bit 3 is 0, strobes leave the history unchanged.
- R4: While the power-loss input is high, bit 4 takes the newest history entry if bit 3 is 1. If bit 3 is 0, it takes the live input value instead (1 when the input is low).
- R5: Bit 4 ignores the write data.
- R6: While bit 7 is 1, writes leave the whole register unchanged.
- R7: A standby reset sets bits 1:0 to 1 and clears bit 7. It leaves bits 2-6 unchanged.
- R8: A main-power or bus reset clears bit 7 only.
- R9: On standby power-up, policy 01 means turn on, 10 means turn on only if bit 4 is 1, and 00 or 11 mean stay off. No pulse is produced while bit 2 is 0.
- R10: When a pulse is due, the button output is low for exactly PULSE_CYCLES cycles (16 by default), starting on the first clock edge after the standby reset is released. There is at most one pulse per release.
- R11: A battery reset clears bits 2-6 and leaves bits 0, 1 and 7 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_bat_n | input | 1 | Battery power-on reset, active low, asynchronous |
| rst_stby_n | input | 1 | Standby power-on reset, active low, asynchronous |
| rst_main_n | input | 1 | Main-power or bus reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| ps_on_n | input | 1 | Supply-on pin state, active low |
| sample_tick | input | 1 | Slow sampling strobe, one cycle wide |
| pwr_lost | input | 1 | Power-loss indication, active high |
| pb_out_n | output | 1 | Power-button pulse, active low |

## Verification
The hardest case to reach is the "previous state" restore. It depends on history captured before a simulated power loss, and on a bit that must survive a standby reset. The bench first enables sampling and strobes in a known pin level. It then raises the power-loss input, programs the policy, and pulses only the standby reset, measuring the start and width of the button pulse. It also changes the pin without a strobe, and strobes with sampling disabled, to show that bit 4 follows the history and not the live pin.

// File: rtl/pwr_restore_pkg.sv
package pwr_restore_pkg;

    typedef enum logic [1:0] {
        POL_STAY_OFF = 2'b00,
        POL_TURN_ON  = 2'b01,
        POL_PREVIOUS = 2'b10,
        POL_OFF_ALT  = 2'b11
    } restore_pol_t;

    // fields kept alive by the battery domain
    typedef struct packed {
        restore_pol_t policy;
        logic         prev_on;
        logic         samp_en;
        logic         rec_en;
    } bat_fields_t;

    // fields restored by the standby power-on reset
    typedef struct packed {
        logic kb_btn_en;
        logic btn_en;
    } stby_fields_t;

endpackage

// File: rtl/prs_history.sv
module prs_history #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic pin_on_i,
    output logic newest_o
);
    logic [DEPTH-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (en_i && tick_i) begin
            hist_d = {hist_q[DEPTH-2:0], pin_on_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign newest_o = hist_q[0];

    p_hist_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(hist_q))
        else $error("history changed while sampling disabled");

    p_hist_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i) |=> (newest_o == $past(pin_on_i)))
        else $error("newest history entry does not match sampled pin");

endmodule

// File: rtl/prs_restore.sv
module prs_restore
    import pwr_restore_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  restore_pol_t policy_i,
    input  logic         rec_en_i,
    input  logic         prev_on_i,
    output logic         pb_out_n
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } rs_state_t;

    rs_state_t st_d, st_q;
    logic      want_on;

    always_comb begin
        unique case (policy_i)
            POL_TURN_ON:  want_on = 1'b1;
            POL_PREVIOUS: want_on = prev_on_i;
            default:      want_on = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        if (st_q.armed) begin
            st_d.armed = 1'b0;
            if (rec_en_i && want_on) st_d.cnt = CNT_W'(PULSE_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed <= 1'b1;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pb_out_n = (st_q.cnt == '0);

    p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && pb_out_n) |=> pb_out_n)
        else $error("second button pulse in one power-up");

    p_pulse_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pb_out_n) |-> $past(rec_en_i))
        else $error("button pulse with recovery disabled");

endmodule

// File: rtl/pwr_restore_ctrl.sv
module pwr_restore_ctrl
    import pwr_restore_pkg::*;
#(
    parameter int HIST_DEPTH   = 8,
    parameter int PULSE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_bat_n,
    input  logic       rst_stby_n,
    input  logic       rst_main_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       ps_on_n,
    input  logic       sample_tick,
    input  logic       pwr_lost,
    output logic       pb_out_n
);
    bat_fields_t  bat_d, bat_q;
    stby_fields_t stby_d, stby_q;
    logic         lock_d, lock_q;
    logic         lock_rst_n;
    logic         hist_newest;

    assign lock_rst_n = rst_stby_n & rst_main_n;

    prs_history #(.DEPTH(HIST_DEPTH)) u_hist (
        .clk      (clk),
        .rst_n    (rst_stby_n),
        .en_i     (bat_q.samp_en),
        .tick_i   (sample_tick),
        .pin_on_i (~ps_on_n),
        .newest_o (hist_newest)
    );

    prs_restore #(.PULSE_CYCLES(PULSE_CYCLES)) u_restore (
        .clk       (clk),
        .rst_n     (rst_stby_n),
        .policy_i  (bat_q.policy),
        .rec_en_i  (bat_q.rec_en),
        .prev_on_i (bat_q.prev_on),
        .pb_out_n  (pb_out_n)
    );

    always_comb begin
        bat_d  = bat_q;
        stby_d = stby_q;
        lock_d = lock_q;
        if (wr_en && !lock_q) begin
            lock_d           = wr_data[7];
            bat_d.policy     = restore_pol_t'(wr_data[6:5]);
            bat_d.samp_en    = wr_data[3];
            bat_d.rec_en     = wr_data[2];
            stby_d.kb_btn_en = wr_data[1];
            stby_d.btn_en    = wr_data[0];
        end
        if (pwr_lost) begin
            bat_d.prev_on = bat_q.samp_en ? hist_newest : ~ps_on_n;
        end
    end

    always_ff @(posedge clk or negedge rst_bat_n) begin
        if (!rst_bat_n) bat_q <= '0;
        else            bat_q <= bat_d;
    end

    always_ff @(posedge clk or negedge rst_stby_n) begin
        if (!rst_stby_n) stby_q <= '1;
        else             stby_q <= stby_d;
    end

    always_ff @(posedge clk or negedge lock_rst_n) begin
        if (!lock_rst_n) lock_q <= 1'b0;
        else             lock_q <= lock_d;
    end

    assign rd_data = {lock_q, bat_q.policy, bat_q.prev_on, bat_q.samp_en,
                      bat_q.rec_en, stby_q.kb_btn_en, stby_q.btn_en};

    p_locked_frozen_r6: assert property (@(posedge clk)
        disable iff (!rst_bat_n || !rst_stby_n || !rst_main_n)
        (lock_q && wr_en) |=> ($stable(rd_data[7:5]) && $stable(rd_data[3:0])))
        else $error("locked register changed on write");

    p_prev_readonly_r5: assert property (@(posedge clk)
        disable iff (!rst_bat_n || !rst_stby_n || !rst_main_n)
        (wr_en && !pwr_lost) |=> $stable(rd_data[4]))
        else $error("previous-state bit changed by a write");

    p_prev_capture_r4: assert property (@(posedge clk)
        disable iff (!rst_bat_n || !rst_stby_n || !rst_main_n)
        (pwr_lost && !rd_data[3]) |=> (rd_data[4] == !$past(ps_on_n)))
        else $error("previous-state bit missed live pin");

endmodule

// File: tb/pwr_restore_ctrl_test.sv
module pwr_restore_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_bat_n = 1'b0, rst_stby_n = 1'b0, rst_main_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ps_on_n = 1'b1;
    logic       sample_tick = 1'b0;
    logic       pwr_lost = 1'b0;
    logic       pb_out_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    pwr_restore_ctrl uut (
        .clk(clk), .rst_bat_n(rst_bat_n), .rst_stby_n(rst_stby_n),
        .rst_main_n(rst_main_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ps_on_n(ps_on_n), .sample_tick(sample_tick),
        .pwr_lost(pwr_lost), .pb_out_n(pb_out_n)
    );

    // monitor: pops expected register values and compares them
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (rd_data !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: rd_data=%02h expected=%02h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    task automatic expect_reg(input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic check_int(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic lose();
        @(negedge clk);
        pwr_lost = 1'b1;
        @(negedge clk);
        pwr_lost = 1'b0;
    endtask

    // pulse standby reset and measure the button pulse
    task automatic stby_cycle(input int exp_len, input string tag);
        int first = -1;
        int lows = 0;
        @(negedge clk);
        rst_stby_n = 1'b0;
        repeat (2) @(negedge clk);
        check_int(int'(pb_out_n), 1, {tag, " idle in reset"});
        rst_stby_n = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!pb_out_n) begin
                lows++;
                if (first < 0) first = i;
            end
        end
        check_int(lows, exp_len, {tag, " pulse length"});
        if (exp_len > 0) check_int(first, 0, {tag, " pulse start"});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_bat_n = 1'b1; rst_main_n = 1'b1; rst_stby_n = 1'b1;
        @(negedge clk);
        expect_reg(8'h03, "R1 R11 power-on defaults");

        wr(8'h0F);
        expect_reg(8'h0F, "R2 write low bits");
        wr(8'h00);
        expect_reg(8'h00, "R2 write clear");
        wr(8'h10);
        expect_reg(8'h00, "R5 bit4 ignores write");

        // live capture with sampling disabled
        ps_on_n = 1'b0;
        lose();
        expect_reg(8'h10, "R4 live pin on");
        ps_on_n = 1'b1;
        lose();
        expect_reg(8'h00, "R4 live pin off");

        // history capture
        wr(8'h08);
        ps_on_n = 1'b0;
        tick();
        lose();
        expect_reg(8'h18, "R3 sampled on");
        ps_on_n = 1'b1;
        lose();
        expect_reg(8'h18, "R4 newest history, not live pin");
        tick();
        lose();
        expect_reg(8'h08, "R3 sampled off");
        wr(8'h00);
        ps_on_n = 1'b0;
        tick();
        tick();
        wr(8'h08);
        lose();
        expect_reg(8'h08, "R3 history held while disabled");

        // restore previous state: on
        tick();
        lose();
        expect_reg(8'h18, "R3 sampled on again");
        wr(8'h4C);
        expect_reg(8'h5C, "R2 policy previous");
        stby_cycle(16, "R9 R10 previous-on");
        expect_reg(8'h5F, "R7 standby reset keeps bits 2-6");

        // restore previous state: off
        ps_on_n = 1'b1;
        tick();
        lose();
        expect_reg(8'h4F, "R4 previous off");
        stby_cycle(0, "R9 previous-off");

        wr(8'h23);
        stby_cycle(0, "R9 recovery disabled");
        wr(8'h27);
        stby_cycle(16, "R9 R10 turn on");
        wr(8'h67);
        stby_cycle(0, "R9 policy 11 off");
        wr(8'h07);
        stby_cycle(0, "R9 policy 00 off");

        // lock behaviour
        wr(8'h87);
        expect_reg(8'h87, "R6 lock set");
        wr(8'h00);
        expect_reg(8'h87, "R6 locked write ignored");
        @(negedge clk);
        rst_main_n = 1'b0;
        @(negedge clk);
        rst_main_n = 1'b1;
        expect_reg(8'h07, "R8 main reset clears lock only");
        wr(8'h03);
        expect_reg(8'h03, "R8 writable after main reset");
        wr(8'h80);
        stby_cycle(0, "R7 locked standby reset");
        expect_reg(8'h03, "R7 standby reset clears lock sets 1:0");

        // battery reset
        wr(8'h00);
        ps_on_n = 1'b0;
        lose();
        wr(8'h6C);
        expect_reg(8'h7C, "R11 setup");
        @(negedge clk);
        rst_bat_n = 1'b0;
        @(negedge clk);
        rst_bat_n = 1'b1;
        expect_reg(8'h00, "R11 battery reset clears 2-6 only");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule